// File: doc/BRIEF.md
# Key-Driven Serial Bit Permuter

This block takes two 512-bit intermediate digests, joins them into a single 1024-bit vector and scatters its bits into a 1024-bit output register. A run-time key sets the placement. The key is a table of 1024 entries, each 10 bits wide. Entry `i` names the output position that receives bit `i` of the joined vector. Software or a neighbouring controller loads the table through a simple write port while the block is idle. A start strobe then launches one permutation.

The block moves one bit per clock. A counter walks the source positions from 0 up to 1023. On each cycle it reads the key entry at the counter value and copies that source bit to the output position the entry names. After the last bit has been placed, a one-cycle done pulse marks the output as valid. The output then holds its value until the next accepted start. The block does not check whether the key is a true permutation: a repeated destination overwrites the earlier bit, and an unused destination stays zero.

Top module: `keyed_bit_permuter`

## Requirements
- R1: After a synchronous reset, and when reset is asserted during a run, `sig_o` is all zeros, `done_o` is low, and no run is in progress, so no done pulse follows.
- R2: The joined vector carries `digest_a_i` in bits 1023..512 and `digest_b_i` in bits 511..0. With an identity key, `sig_o[1023:512]` equals `digest_a_i` and `sig_o[511:0]` equals `digest_b_i`.
- R3: After a run, for every source position i, `sig_o[key[i]]` equals bit i of the joined vector. Key entries are unsigned 10-bit output positions.
- R4: If a start is sampled on clock edge E0 while idle, `done_o` is high exactly in the cycle that follows edge E0+1024 and is low in every other cycle of the run and the cycle after.
- R5: An accepted start clears `sig_o` to zero on its own edge. While idle with no start, `sig_o` holds its value.
- R6: A start that arrives during a run is ignored. The run keeps its count and its result.
- R7: A key write that arrives during a run is ignored. The table entry keeps its old value for later runs.
- R8: The digests are captured on the accepted start edge. Changes to `digest_a_i` or `digest_b_i` during a run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a permutation (accepted only when idle) |
| digest_a_i | input | 512 | First digest, placed in the upper half |
| digest_b_i | input | 512 | Second digest, placed in the lower half |
| key_we_i | input | 1 | Key table write enable (idle only) |
| key_addr_i | input | 10 | Key table entry to write (source bit index) |
| key_data_i | input | 10 | Destination position for that source bit |
| sig_o | output | 1024 | Permuted signature register |
| done_o | output | 1 | One-cycle pulse when all bits are placed |

## Verification
The clear of `sig_o` is due one edge after the start and is sampled just after that edge. `done_o` is due 1024 edges after the start. The bench counts edges from the start and samples after each one, so it can confirm that `done_o` is low up to edge 1023, high after edge 1024 and low again after edge 1025. The permuted result is compared once done has been seen, against a vector the bench builds from its own copy of the key. The checks for ignored stimulus (a start, a key write and changed digests, all issued in the middle of a run) are made on that run's final result and on a second run that reuses the same key.

// File: rtl/perm_pkg.sv
package perm_pkg;

    // Default size of the joined vector (two equal digest halves).
    localparam int unsigned PERM_BITS_DEF = 1024;

    // Sequencer states.
    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_RUN  = 1'b1
    } perm_state_e;

    // Control bundle from the sequencer to the datapath.
    typedef struct packed {
        logic load;   // accepted start: capture source, clear output
        logic step;   // move one bit this cycle
        logic last;   // this step places the final bit
    } perm_ctrl_t;

    // Index width for a vector of n bits.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/perm_key_store.sv
module perm_key_store
    import perm_pkg::*;
#(
    parameter int unsigned DEPTH = PERM_BITS_DEF,
    localparam int unsigned AW   = idx_width(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [AW-1:0] rd_data
);

    logic [AW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read: destination is available in the same step cycle.
    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/perm_sequencer.sv
module perm_sequencer
    import perm_pkg::*;
#(
    parameter int unsigned N_BITS = PERM_BITS_DEF,
    localparam int unsigned IW    = idx_width(N_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output perm_ctrl_t    ctrl_o,
    output logic [IW-1:0] idx_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N_BITS - 1);

    perm_state_e   state_q, state_d;
    logic [IW-1:0] cnt_q, cnt_d;
    logic          done_q, done_d;

    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        done_d      = 1'b0;
        ctrl_o.load = 1'b0;
        ctrl_o.step = 1'b0;
        ctrl_o.last = 1'b0;
        unique case (state_q)
            PS_IDLE: begin
                if (start_i) begin
                    ctrl_o.load = 1'b1;
                    state_d     = PS_RUN;
                    cnt_d       = '0;
                end
            end
            PS_RUN: begin
                ctrl_o.step = 1'b1;
                if (cnt_q == LAST_IDX) begin
                    ctrl_o.last = 1'b1;
                    state_d     = PS_IDLE;
                    cnt_d       = '0;
                    done_d      = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    assign idx_o  = cnt_q;
    assign busy_o = (state_q == PS_RUN);
    assign done_o = done_q;

endmodule

// File: rtl/perm_scatter_reg.sv
module perm_scatter_reg
    import perm_pkg::*;
#(
    parameter int unsigned N_BITS = PERM_BITS_DEF,
    localparam int unsigned IW    = idx_width(N_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  perm_ctrl_t        ctrl_i,
    input  logic [N_BITS-1:0] vec_i,
    input  logic [IW-1:0]     src_idx_i,
    input  logic [IW-1:0]     dst_idx_i,
    output logic [N_BITS-1:0] sig_o
);

    logic [N_BITS-1:0] src_q;
    logic [N_BITS-1:0] out_q;
    logic [N_BITS-1:0] hit;
    logic              src_bit;

    // Source vector captured on the accepted start.
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
        end else if (ctrl_i.load) begin
            src_q <= vec_i;
        end
    end

    assign src_bit = src_q[src_idx_i];

    // One-hot destination decode.
    for (genvar j = 0; j < N_BITS; j++) begin : g_dec
        assign hit[j] = ctrl_i.step && (dst_idx_i == IW'(j));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (ctrl_i.load) begin
            out_q <= '0;
        end else if (ctrl_i.step) begin
            out_q <= (out_q & ~hit) | ({N_BITS{src_bit}} & hit);
        end
    end

    assign sig_o = out_q;

endmodule

// File: rtl/keyed_bit_permuter.sv
module keyed_bit_permuter
    import perm_pkg::*;
#(
    parameter int unsigned N_BITS = PERM_BITS_DEF,
    localparam int unsigned HALF  = N_BITS / 2,
    localparam int unsigned IW    = idx_width(N_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [HALF-1:0]   digest_a_i,
    input  logic [HALF-1:0]   digest_b_i,
    input  logic              key_we_i,
    input  logic [IW-1:0]     key_addr_i,
    input  logic [IW-1:0]     key_data_i,
    output logic [N_BITS-1:0] sig_o,
    output logic              done_o
);

    perm_ctrl_t        ctrl;
    logic [IW-1:0]     cnt;
    logic [IW-1:0]     dst;
    logic              busy;
    logic              key_wr;
    logic [N_BITS-1:0] joined;

    assign joined = {digest_a_i, digest_b_i};
    assign key_wr = key_we_i && !busy;

    perm_sequencer #(.N_BITS(N_BITS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctrl_o  (ctrl),
        .idx_o   (cnt),
        .busy_o  (busy),
        .done_o  (done_o)
    );

    perm_key_store #(.DEPTH(N_BITS)) u_key (
        .clk     (clk),
        .wr_en   (key_wr),
        .wr_addr (key_addr_i),
        .wr_data (key_data_i),
        .rd_addr (cnt),
        .rd_data (dst)
    );

    perm_scatter_reg #(.N_BITS(N_BITS)) u_scatter (
        .clk       (clk),
        .rst       (rst),
        .ctrl_i    (ctrl),
        .vec_i     (joined),
        .src_idx_i (cnt),
        .dst_idx_i (dst),
        .sig_o     (sig_o)
    );

endmodule

// File: rtl/keyed_bit_permuter_chk.sv
module keyed_bit_permuter_chk
    import perm_pkg::*;
#(
    parameter int unsigned N_BITS = PERM_BITS_DEF,
    localparam int unsigned IW    = idx_width(N_BITS)
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              done_o,
    input logic [N_BITS-1:0] sig_o,
    input logic              busy,
    input logic [IW-1:0]     cnt,
    input logic              key_wr
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N_BITS - 1);

    // R4: done is a single-cycle pulse
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4: done follows the final step and the run ends
    p_done_after_last_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == LAST_IDX) |=> (done_o && !busy));

    // R5: output held while idle without a start
    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_i) |=> $stable(sig_o));

    // R5: accepted start clears the output
    p_clear_on_start_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_i) |=> (sig_o == '0 && busy && cnt == '0));

    // R6: a run advances one position per cycle regardless of start
    p_run_advance_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != LAST_IDX) |=> (busy && cnt == $past(cnt) + 1'b1));

    // R7: no key table write lands during a run
    p_no_key_write_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !key_wr);

endmodule

bind keyed_bit_permuter keyed_bit_permuter_chk #(.N_BITS(N_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .done_o  (done_o),
    .sig_o   (sig_o),
    .busy    (busy),
    .cnt     (cnt),
    .key_wr  (key_wr)
);

// File: tb/sim_keyed_bit_permuter.sv
module sim_keyed_bit_permuter;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 1024;
    localparam int HALF = N / 2;
    localparam int IW   = 10;

    // Vector table: {disturb, mode[2:0], param[9:0], seed[31:0]}
    // mode 0 identity, 1 reverse, 2 rotate by param, 3 xor with param, 4 affine i*param+3
    localparam int NV = 6;
    localparam logic [45:0] VEC [NV] = '{
        {1'b0, 3'd0, 10'd0,   32'h0000_1001},
        {1'b0, 3'd1, 10'd0,   32'h0000_2002},
        {1'b1, 3'd2, 10'd37,  32'h0000_3003},
        {1'b0, 3'd3, 10'h2A5, 32'h0000_4004},
        {1'b1, 3'd4, 10'd389, 32'h0000_5005},
        {1'b0, 3'd2, 10'd1,   32'h0000_6006}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [HALF-1:0] digest_a = '0;
    logic [HALF-1:0] digest_b = '0;
    logic            key_we = 1'b0;
    logic [IW-1:0]   key_addr = '0;
    logic [IW-1:0]   key_data = '0;
    logic [N-1:0]    sig;
    logic            done;

    int tests = 0;
    int fails = 0;
    int kmodel [N];

    always #(CLK_PERIOD / 2) clk = ~clk;

    keyed_bit_permuter u0 (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .digest_a_i (digest_a),
        .digest_b_i (digest_b),
        .key_we_i   (key_we),
        .key_addr_i (key_addr),
        .key_data_i (key_data),
        .sig_o      (sig),
        .done_o     (done)
    );

    task automatic check(input bit ok, input string req, input string msg);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic int key_of(input int mode, input int p, input int i);
        case (mode)
            0: return i;
            1: return N - 1 - i;
            2: return (i + p) % N;
            3: return i ^ p;
            default: return (i * p + 3) % N;
        endcase
    endfunction

    function automatic logic [HALF-1:0] make_digest(input logic [31:0] seed);
        logic [63:0] s;
        logic [HALF-1:0] d;
        s = {seed, ~seed} ^ 64'h9E37_79B9_7F4A_7C15;
        for (int w = 0; w < HALF / 64; w++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 7);
            s = s ^ (s << 17);
            d[w*64 +: 64] = s;
        end
        return d;
    endfunction

    task automatic load_key(input int mode, input int p);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            kmodel[i] = key_of(mode, p, i);
            key_we    = 1'b1;
            key_addr  = IW'(i);
            key_data  = IW'(kmodel[i]);
        end
        @(negedge clk);
        key_we = 1'b0;
    endtask

    // One permutation; disturb issues a start, a key write and new digests mid-run.
    task automatic run_op(input logic [HALF-1:0] a, input logic [HALF-1:0] b,
                          input bit disturb, input string req);
        logic [N-1:0] v;
        logic [N-1:0] ex;
        int early_done;
        logic done_at_n;
        v  = {a, b};
        ex = '0;
        for (int i = 0; i < N; i++) ex[kmodel[i]] = v[i];
        @(negedge clk);
        digest_a = a;
        digest_b = b;
        start    = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        check(sig == '0, "R5", $sformatf("output not cleared at start, got %h expected 0", sig));
        early_done = 0;
        done_at_n  = 1'b0;
        for (int k = 1; k <= N; k++) begin
            @(posedge clk);
            #1;
            if (k < N && done) early_done++;
            if (k == N) done_at_n = done;
            if (disturb && k == 100) begin
                start    = 1'b1;
                digest_a = ~a;
                digest_b = ~b;
                key_we   = 1'b1;
                key_addr = IW'(5);
                key_data = IW'((kmodel[5] + 1) % N);
            end
            if (disturb && k == 101) begin
                start  = 1'b0;
                key_we = 1'b0;
            end
        end
        check(early_done == 0, "R4", $sformatf("done early %0d times expected 0", early_done));
        check(done_at_n == 1'b1, "R4", $sformatf("done after edge N got %0b expected 1", done_at_n));
        @(posedge clk);
        #1;
        check(done == 1'b0, "R4", $sformatf("done lasted 2 cycles got %0b expected 0", done));
        check(sig == ex, req, $sformatf("signature got %h expected %h", sig, ex));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [N-1:0] held;
        int stray;
        repeat (3) @(posedge clk);
        #1;
        check(sig == '0, "R1", $sformatf("reset output got %h expected 0", sig));
        check(done == 1'b0, "R1", $sformatf("reset done got %0b expected 0", done));
        @(negedge clk);
        rst = 1'b0;

        for (int e = 0; e < NV; e++) begin
            logic [HALF-1:0] a;
            logic [HALF-1:0] b;
            a = make_digest(VEC[e][31:0]);
            b = make_digest(~VEC[e][31:0]);
            load_key(int'(VEC[e][44:42]), int'(VEC[e][41:32]));
            if (VEC[e][45]) begin
                // R6 R8: mid-run start and digest change ignored
                run_op(a, b, 1'b1, "R6");
                // R7: mid-run key write ignored, same key reused
                run_op(b, a, 1'b0, "R7");
            end else begin
                run_op(a, b, 1'b0, "R3");
            end
            if (VEC[e][44:42] == 3'd0) begin
                check(sig[N-1:HALF] == a, "R2", $sformatf("upper half got %h expected %h", sig[N-1:HALF], a));
                check(sig[HALF-1:0] == b, "R2", $sformatf("lower half got %h expected %h", sig[HALF-1:0], b));
            end
        end

        // R8: digest inputs at ~a/~b during run already covered; check output holds idle (R5)
        held = sig;
        @(negedge clk);
        digest_a = '1;
        digest_b = '0;
        repeat (20) @(posedge clk);
        #1;
        check(sig == held, "R5", $sformatf("idle output changed got %h expected %h", sig, held));
        check(done == 1'b0, "R5", $sformatf("idle done got %0b expected 0", done));

        // R8: inputs changed every cycle of a run
        begin
            logic [HALF-1:0] a2;
            logic [HALF-1:0] b2;
            logic [N-1:0] ex2;
            a2 = make_digest(32'hABCD_0001);
            b2 = make_digest(32'hABCD_0002);
            ex2 = '0;
            for (int i = 0; i < N; i++) ex2[kmodel[i]] = ({a2, b2} >> i) & 1'b1 ? 1'b1 : 1'b0;
            @(negedge clk);
            digest_a = a2;
            digest_b = b2;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < N + 2; k++) begin
                @(negedge clk);
                digest_a = make_digest(32'(k));
                digest_b = ~digest_a;
            end
            check(sig == ex2, "R8", $sformatf("signature got %h expected %h", sig, ex2));
        end

        // R1: reset during a run
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(sig == '0, "R1", $sformatf("mid-run reset output got %h expected 0", sig));
        check(done == 1'b0, "R1", $sformatf("mid-run reset done got %0b expected 0", done));
        @(negedge clk);
        rst = 1'b0;
        stray = 0;
        for (int k = 0; k < N + 8; k++) begin
            @(posedge clk);
            #1;
            if (done) stray++;
        end
        check(stray == 0, "R1", $sformatf("done after aborted run %0d times expected 0", stray));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule